// File: doc/BRIEF.md
# Grouped Lookahead Adder-Subtractor

This block adds or subtracts two two's-complement operands in a single combinational pass. The operand width is split into fixed-size lookahead groups of four bits. Inside a group, every carry is computed at once from per-bit generate and propagate terms and the group's incoming carry. Between groups the carry travels in series, one group after another. The datapath is therefore much shallower than a bit-serial ripple chain, without needing a second lookahead tier.

A mode input selects the operation. For subtraction the block reuses the same adder: a small control stage tells the datapath to complement every bit of the second operand and to inject a one at the lowest carry input. Three outputs are produced: the wrapped result, the raw carry out of the top group, and a signed overflow flag. The overflow flag is the XOR of the carry entering the most significant bit and the carry leaving it. The number of groups is a parameter, so the same source serves a narrow 8-bit instance and the default 16-bit one.

Top module: `grouped_addsub`

## Requirements
- R1: With subMode = 0, result equals (opA + opB) modulo 2^WIDTH, where WIDTH = 4 × NUM_GROUPS.
- R2: With subMode = 1, result equals (opA − opB) modulo 2^WIDTH.
- R3: With subMode = 0, carryOut equals bit WIDTH of the unsigned sum opA + opB.
- R4: With subMode = 1, carryOut is 1 exactly when opA ≥ opB as unsigned numbers, meaning no borrow occurred.
- R5: overflow is 1 exactly when the true signed result of the selected operation lies outside the range from −2^(WIDTH−1) to 2^(WIDTH−1)−1.
- R6: When the two effective addends have opposite signs, overflow is 0. The effective addends are opA and either opB (add) or the complement of opB (subtract). When overflow is 1, the result sign differs from the common sign of the addends.
- R7: For an 8-bit instance, 0x48 + 0x39 gives 0x81 with overflow 1 and carryOut 0. 0x81 + 0xFA gives 0x7B with overflow 1 and carryOut 1.
- R8: A carry produced in one 4-bit group reaches every higher group. For example, 0x0FFF + 0x0001 gives 0x1000, and 0xFFFF + 0x0001 gives 0x0000 with carryOut 1.
- R9: Each 4-bit group's sum and carry-out equal the arithmetic sum of its two 4-bit inputs and its carry-in.
- R10: Subtract mode drives both the operand-inversion strobe and the group-0 carry-in to 1, and add mode drives both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand (two's complement or unsigned) |
| opB | input | WIDTH | Second operand |
| subMode | input | 1 | 0 = add, 1 = subtract (opA − opB) |
| result | output | WIDTH | Wrapped sum or difference |
| carryOut | output | 1 | Carry out of the top group; in subtract mode 1 means no borrow |
| overflow | output | 1 | Signed overflow of the selected operation |

## Verification
Carry-out and signed overflow are produced by the same top-group carries, so they can be set together, and the bench provokes every such case. It sweeps all operand pairs in both modes on an 8-bit instance and drives random and corner vectors (0x0000, 0x7FFF, 0x8000, 0xFFFF) on the 16-bit instance. Both flags are judged independently against a wide integer model: carry from the unsigned sum or the unsigned comparison, overflow from range tests on the signed result. Cases where both flags are set together, such as 0x81 + 0xFA and 0x8000 − 0x0001, are also checked as directed vectors.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int DEFAULT_GROUP_W = 4;

  // Strobes from the mode control into the datapath
  typedef struct packed {
    logic invertB;
    logic carryIn;
  } addsubStrobes_t;

endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GROUP_W = addsub_pkg::DEFAULT_GROUP_W
) (
  input  logic [GROUP_W-1:0] a,
  input  logic [GROUP_W-1:0] b,
  input  logic               cin,
  output logic [GROUP_W-1:0] sum,
  output logic               cout,
  output logic               msbCarryIn
);

  localparam int EXT_W = GROUP_W + 1;

  logic [GROUP_W-1:0] gen;
  logic [GROUP_W-1:0] prop;
  logic [GROUP_W:0]   carry;

  // Each carry is a flat sum of products of generate, propagate and cin
  always_comb begin
    logic acc;
    logic term;
    gen      = a & b;
    prop     = a ^ b;
    carry    = '0;
    carry[0] = cin;
    for (int j = 0; j < GROUP_W; j++) begin
      acc = cin;
      for (int k = 0; k <= j; k++) acc = acc & prop[k];
      for (int k = 0; k <= j; k++) begin
        term = gen[k];
        for (int m = k + 1; m <= j; m++) term = term & prop[m];
        acc = acc | term;
      end
      carry[j+1] = acc;
    end
  end

  assign sum        = prop ^ carry[GROUP_W-1:0];
  assign cout       = carry[GROUP_W];
  assign msbCarryIn = carry[GROUP_W-1];

  // R9
  always_comb begin
    group_sum_chk: assert ({cout, sum} ==
                           ({1'b0, a} + {1'b0, b} + EXT_W'(cin)))
      else $error("group lookahead sum mismatch");
  end

endmodule

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic           subMode,
  output addsubStrobes_t strobes
);

  always_comb begin
    strobes.invertB = subMode;
    strobes.carryIn = subMode;
  end

  // R10
  always_comb begin
    strobe_mode_chk: assert (strobes.invertB == subMode &&
                             strobes.carryIn == strobes.invertB)
      else $error("mode strobes inconsistent");
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = DEFAULT_GROUP_W,
  localparam int WIDTH     = NUM_GROUPS * GROUP_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  addsubStrobes_t   strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);

  logic [WIDTH-1:0]      opBEff;
  logic [NUM_GROUPS:0]   grpCarry;
  logic [NUM_GROUPS-1:0] grpMsbCarry;

  assign opBEff      = opB ^ {WIDTH{strobes.invertB}};
  assign grpCarry[0] = strobes.carryIn;

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_group
    cla_group #(.GROUP_W(GROUP_W)) u_group (
      .a          (opA[gi*GROUP_W +: GROUP_W]),
      .b          (opBEff[gi*GROUP_W +: GROUP_W]),
      .cin        (grpCarry[gi]),
      .sum        (result[gi*GROUP_W +: GROUP_W]),
      .cout       (grpCarry[gi+1]),
      .msbCarryIn (grpMsbCarry[gi])
    );
  end

  assign carryOut = grpCarry[NUM_GROUPS];
  assign overflow = grpMsbCarry[NUM_GROUPS-1] ^ carryOut;

  // R6
  always_comb begin
    mixed_sign_chk: assert (!(opA[WIDTH-1] != opBEff[WIDTH-1] && overflow))
      else $error("overflow with opposite-sign addends");
  end

  // R6
  always_comb begin
    ovf_sign_flip_chk: assert (!overflow ||
                               (opA[WIDTH-1] == opBEff[WIDTH-1] &&
                                result[WIDTH-1] != opA[WIDTH-1]))
      else $error("overflow without sign flip");
  end

  // R4
  always_comb begin
    equal_sub_chk: assert (!(strobes.invertB && strobes.carryIn && opA == opB) ||
                           (result == '0 && carryOut))
      else $error("A-A must give zero with no borrow");
  end

endmodule

// File: rtl/grouped_addsub.sv
module grouped_addsub
  import addsub_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = DEFAULT_GROUP_W,
  localparam int WIDTH     = NUM_GROUPS * GROUP_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);

  addsubStrobes_t strobes;

  addsub_ctrl u_ctrl (
    .subMode (subMode),
    .strobes (strobes)
  );

  addsub_datapath #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
  ) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow)
  );

endmodule

// File: tb/grouped_addsub_bench.sv
module grouped_addsub_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  logic [15:0] a16, b16, r16;
  logic        s16, c16, o16;
  logic [7:0]  a8, b8, r8;
  logic        s8, c8, o8;

  grouped_addsub #(.NUM_GROUPS(4)) u_grouped_addsub (
    .opA(a16), .opB(b16), .subMode(s16),
    .result(r16), .carryOut(c16), .overflow(o16)
  );

  grouped_addsub #(.NUM_GROUPS(2)) u_narrow (
    .opA(a8), .opB(b8), .subMode(s8),
    .result(r8), .carryOut(c8), .overflow(o8)
  );

  // Behavioural reference at wide width
  function automatic void model(input int w, input longint ua, input longint ub,
                                input bit sub, output longint res,
                                output bit cy, output bit ov);
    longint mask = (64'sd1 <<< w) - 1;
    longint sa   = (ua >= (64'sd1 <<< (w-1))) ? ua - (64'sd1 <<< w) : ua;
    longint sb   = (ub >= (64'sd1 <<< (w-1))) ? ub - (64'sd1 <<< w) : ub;
    longint sres = sub ? sa - sb : sa + sb;
    longint ures = sub ? ua - ub : ua + ub;
    res = ures & mask;
    cy  = sub ? (ua >= ub) : (ures > mask);
    ov  = (sres > (64'sd1 <<< (w-1)) - 1) || (sres < -(64'sd1 <<< (w-1)));
  endfunction

  task automatic compare(input string req, input longint gotR, input bit gotC,
                         input bit gotO, input longint expR, input bit expC,
                         input bit expO);
    checks++;
    if (gotR != expR || gotC != expC || gotO != expO) begin
      failures++;
      $display("FAIL %s: got res=%0h cy=%0b ov=%0b expected res=%0h cy=%0b ov=%0b",
               req, gotR, gotC, gotO, expR, expC, expO);
    end
  endtask

  task automatic run16(input string req, input logic [15:0] a, input logic [15:0] b,
                       input bit sub);
    longint er; bit ec, eo;
    @(posedge clk);
    a16 = a; b16 = b; s16 = sub;
    @(negedge clk);
    model(16, longint'(a), longint'(b), sub, er, ec, eo);
    compare(req, longint'(r16), c16, o16, er, ec, eo);
  endtask

  task automatic run8(input string req, input logic [7:0] a, input logic [7:0] b,
                      input bit sub);
    longint er; bit ec, eo;
    @(posedge clk);
    a8 = a; b8 = b; s8 = sub;
    @(negedge clk);
    model(8, longint'(a), longint'(b), sub, er, ec, eo);
    compare(req, longint'(r8), c8, o8, er, ec, eo);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a16 = '0; b16 = '0; s16 = 1'b0;
    a8  = '0; b8  = '0; s8  = 1'b0;
    @(negedge clk);
    // Idle state: zero operands give zero outputs (R1)
    compare("R1 idle", longint'(r16), c16, o16, 0, 1'b0, 1'b0);

    // R7 directed 8-bit overflow cases
    run8("R7 72+57", 8'h48, 8'h39, 1'b0);
    compare("R7 72+57 literal", longint'(r8), c8, o8, 64'h81, 1'b0, 1'b1);
    run8("R7 -127+-6", 8'h81, 8'hFA, 1'b0);
    compare("R7 -127+-6 literal", longint'(r8), c8, o8, 64'h7B, 1'b1, 1'b1);

    // R8 carry crossing group boundaries
    run16("R8 0FFF+1", 16'h0FFF, 16'h0001, 1'b0);
    compare("R8 0FFF+1 literal", longint'(r16), c16, o16, 64'h1000, 1'b0, 1'b0);
    run16("R8 FFFF+1", 16'hFFFF, 16'h0001, 1'b0);
    compare("R8 FFFF+1 literal", longint'(r16), c16, o16, 64'h0000, 1'b1, 1'b0);
    run16("R8 00FF+0F01", 16'h00FF, 16'h0F01, 1'b0);

    // R4 borrow / no-borrow, R6 mixed signs, R10 mode strobes
    run16("R4 5-7 borrow", 16'h0005, 16'h0007, 1'b1);
    compare("R4 5-7 literal", longint'(r16), c16, o16, 64'hFFFE, 1'b0, 1'b0);
    run16("R4 A-A", 16'h1234, 16'h1234, 1'b1);
    compare("R10 A-A literal", longint'(r16), c16, o16, 64'h0000, 1'b1, 1'b0);
    run16("R6 7FFF+8000", 16'h7FFF, 16'h8000, 1'b0);
    compare("R6 7FFF+8000 literal", longint'(r16), c16, o16, 64'hFFFF, 1'b0, 1'b0);
    run16("R5 8000-1", 16'h8000, 16'h0001, 1'b1);
    compare("R5 8000-1 literal", longint'(r16), c16, o16, 64'h7FFF, 1'b1, 1'b1);

    // R1..R5 corner values, both modes
    begin
      logic [15:0] corners [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          run16("R1_R3 corner add", corners[i], corners[j], 1'b0);
          run16("R2_R4 corner sub", corners[i], corners[j], 1'b1);
        end
    end

    // R9 exhaustive 8-bit (2 groups), both modes
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          run8(m ? "R9 R2 R4 R5 exhaustive sub" : "R9 R1 R3 R5 exhaustive add",
               8'(a), 8'(b), bit'(m));

    // Random 16-bit vectors
    for (int n = 0; n < 20000; n++)
      run16("R5 R6 random", 16'($urandom), 16'($urandom), bit'($urandom & 1));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule